// File: doc/BRIEF.md
# Transmit Input Staging Controller

This block is the byte-rate front end of a serial transmitter. It runs on the bit-rate clock and keeps its own byte phase counter. On every byte boundary it decides whether the host's parallel inputs are taken. Those inputs are an 8-bit payload, a special-character flag and a violation request. The block then registers a symbol request for the downstream 8B/10B encoder. In bypass mode it instead presents a raw 10-bit word for the shifter.

Two active-low enables control loading:

- The immediate enable takes the inputs present on the same boundary. It suits an asynchronous FIFO.
- The next-cycle enable takes the inputs present on the following boundary. It suits a clocked FIFO.

When neither enable asks for a load, the block substitutes the comma fill character K28.5. A read strobe is derived from the bit counter, so its low phase has a fixed length in bit times and does not depend on any byte clock duty cycle. It can drive the read input of an asynchronous FIFO.

Top module: `tx_input_stage`

## Requirements
- R1: `byte_tick_o` is high for one clock in every 10 (`BITS_PER_SYM`). The clock edge where it is high is the byte edge, and all inputs are sampled only there.
- R2: If `load_now_ni` is low at a byte edge, the inputs present at that edge are loaded.
- R3: If `load_next_ni` is low at a byte edge, the inputs present at the next byte edge are loaded. If both enables request a load for the same edge, one load takes place.
- R4: A byte edge with no load gives the fill symbol: `sym_kind_o`=3, `sym_byte_o`=0xBC. `raw_o` is 0 in encoded mode and 0x17C (the K28.5 bits, bit 0 sent first) in bypass mode.
- R5: An encoded-mode load with `viol_i` low gives `sym_kind_o`=1 (control) if `ctrl_i` is high and 0 (data) otherwise, with `sym_byte_o`=`data_i` and `raw_o`=0.
- R6: An encoded-mode load with `viol_i` high gives `sym_kind_o`=2 and `sym_byte_o`=0x00, whatever `data_i` and `ctrl_i` are.
- R7: A bypass-mode load gives `sym_kind_o`=0 and `sym_byte_o`=`data_i`. `raw_o[0]`=`ctrl_i` (the first bit sent), `raw_o[8:1]`=`data_i[7:0]` and `raw_o[9]`=`viol_i`.
- R8: The symbol outputs change only on a byte edge. They show the result of that edge from the next clock on and hold it for the whole byte period.
- R9: `rd_strobe_no` is low for the first 6 (`RD_LOW_SLOTS`) clocks of a byte period when `load_now_ni` was low at the edge that opened it. It is high at all other times.
- R10: During reset the symbol outputs read fill (kind 3, byte 0xBC, raw 0) and `rd_strobe_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Payload byte |
| ctrl_i | input | 1 | Special-character flag |
| viol_i | input | 1 | Violation request |
| load_now_ni | input | 1 | Immediate load enable, active low |
| load_next_ni | input | 1 | Next-edge load enable, active low |
| bypass_i | input | 1 | Skip encoding and emit raw 10-bit words |
| byte_tick_o | output | 1 | High in the clock that ends a byte period |
| sym_kind_o | output | 2 | 0 data, 1 control, 2 violation, 3 fill |
| sym_byte_o | output | 8 | Byte for the encoder |
| raw_o | output | 10 | Raw word for the shifter, bit 0 sent first |
| rd_strobe_no | output | 1 | FIFO read strobe, active low |

## Verification
The bench sweeps all 32 combinations of the two enables, the flag, the violation request and the mode, each under eight payload values. This runs as one long sequence, so a next-edge request always meets the enables of the following byte, including the case where both enables point at the same edge. The payload patterns show whether data bits are routed in the right order or dropped, and whether a violation truly masks them. Checking the strobe in each bit slot separates a strobe of the wrong length from one tied to the wrong enable.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;
  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_CTRL = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_FILL = 2'd3
  } sym_kind_e;

  localparam logic [7:0] FILL_BYTE = 8'hBC;
  localparam logic [9:0] FILL_RAW  = 10'h17C;
endpackage

// File: rtl/tx_byte_phase.sv
module tx_byte_phase #(
  parameter int BITS_PER_SYM = 10,
  localparam int CW = $clog2(BITS_PER_SYM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          tick_o,
  output logic [CW-1:0] slot_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS_PER_SYM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
  assign slot_o = cnt_q;
endmodule

// File: rtl/tx_load_ctrl.sv
module tx_load_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_now_ni,
  input  logic load_next_ni,
  output logic load_o,
  output logic now_used_o
);
  logic pend_q;

  // next-edge request held for one byte period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (tick_i) pend_q <= ~load_next_ni;
  end

  assign now_used_o = ~load_now_ni;
  assign load_o     = now_used_o | pend_q;
endmodule

// File: rtl/tx_sym_reg.sv
module tx_sym_reg
  import tx_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RAW_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              bypass_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_i,
  input  logic              viol_i,
  output logic [1:0]        kind_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [RAW_W-1:0]  raw_o
);
  sym_kind_e         kind_d, kind_q;
  logic [DATA_W-1:0] byte_d, byte_q;
  logic [RAW_W-1:0]  raw_d, raw_q;
  logic [RAW_W-1:0]  raw_word;

  // sent order: flag first, payload LSB..MSB, violation last
  assign raw_word[0]       = ctrl_i;
  assign raw_word[RAW_W-1] = viol_i;
  for (genvar g = 0; g < DATA_W; g++) begin : g_raw_map
    assign raw_word[g+1] = data_i[g];
  end

  always_comb begin
    kind_d = SYM_FILL;
    byte_d = FILL_BYTE;
    raw_d  = '0;
    if (!load_i) begin
      if (bypass_i) raw_d = FILL_RAW;
    end else if (bypass_i) begin
      kind_d = SYM_DATA;
      byte_d = data_i;
      raw_d  = raw_word;
    end else if (viol_i) begin
      kind_d = SYM_VIOL;
      byte_d = '0;
    end else begin
      kind_d = ctrl_i ? SYM_CTRL : SYM_DATA;
      byte_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= SYM_FILL;
      byte_q <= FILL_BYTE;
      raw_q  <= '0;
    end else if (tick_i) begin
      kind_q <= kind_d;
      byte_q <= byte_d;
      raw_q  <= raw_d;
    end
  end

  assign kind_o = kind_q;
  assign byte_o = byte_q;
  assign raw_o  = raw_q;
endmodule

// File: rtl/tx_rd_strobe.sv
module tx_rd_strobe #(
  parameter int BITS_PER_SYM = 10,
  parameter int RD_LOW_SLOTS = 6,
  localparam int CW = $clog2(BITS_PER_SYM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] slot_i,
  input  logic          arm_i,
  output logic          rd_no
);
  logic arm_q;
  logic rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      rd_q  <= 1'b1;
    end else if (tick_i) begin
      arm_q <= arm_i;
      rd_q  <= ~arm_i;
    end else begin
      // slot_i + 1 is the slot entered on this edge
      rd_q <= ~(arm_q && ((int'(slot_i) + 1) < RD_LOW_SLOTS));
    end
  end

  assign rd_no = rd_q;
endmodule

// File: rtl/tx_input_stage.sv
module tx_input_stage #(
  parameter int BITS_PER_SYM = 10,
  parameter int RD_LOW_SLOTS = 6,
  parameter int DATA_W       = 8,
  localparam int CW    = $clog2(BITS_PER_SYM),
  localparam int RAW_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_i,
  input  logic              viol_i,
  input  logic              load_now_ni,
  input  logic              load_next_ni,
  input  logic              bypass_i,
  output logic              byte_tick_o,
  output logic [1:0]        sym_kind_o,
  output logic [DATA_W-1:0] sym_byte_o,
  output logic [RAW_W-1:0]  raw_o,
  output logic              rd_strobe_no
);
  logic          tick;
  logic [CW-1:0] slot;
  logic          load;
  logic          now_used;

  tx_byte_phase #(.BITS_PER_SYM(BITS_PER_SYM)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick),
    .slot_o(slot)
  );

  tx_load_ctrl u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .load_now_ni (load_now_ni),
    .load_next_ni(load_next_ni),
    .load_o      (load),
    .now_used_o  (now_used)
  );

  tx_sym_reg #(.DATA_W(DATA_W)) u_sym (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .load_i  (load),
    .bypass_i(bypass_i),
    .data_i  (data_i),
    .ctrl_i  (ctrl_i),
    .viol_i  (viol_i),
    .kind_o  (sym_kind_o),
    .byte_o  (sym_byte_o),
    .raw_o   (raw_o)
  );

  tx_rd_strobe #(
    .BITS_PER_SYM(BITS_PER_SYM),
    .RD_LOW_SLOTS(RD_LOW_SLOTS)
  ) u_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .slot_i(slot),
    .arm_i (now_used),
    .rd_no (rd_strobe_no)
  );

  assign byte_tick_o = tick;
endmodule

// File: rtl/tx_input_stage_chk.sv
module tx_input_stage_chk #(
  parameter int DATA_W = 8,
  localparam int RAW_W = DATA_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_i,
  input logic              viol_i,
  input logic              load_now_ni,
  input logic              load_next_ni,
  input logic              bypass_i,
  input logic              byte_tick_o,
  input logic [1:0]        sym_kind_o,
  input logic [DATA_W-1:0] sym_byte_o,
  input logic [RAW_W-1:0]  raw_o,
  input logic              rd_strobe_no
);
  logic shadow_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shadow_pend <= 1'b0;
    else if (byte_tick_o) shadow_pend <= ~load_next_ni;
  end

  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_tick_o |=> !byte_tick_o);

  a_r2_now_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_tick_o && !load_now_ni) |=> (sym_kind_o != 2'd3));

  a_r3_next_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_tick_o && shadow_pend) |=> (sym_kind_o != 2'd3));

  a_r4_fill_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_tick_o && load_now_ni && !shadow_pend) |=>
      (sym_kind_o == 2'd3 && sym_byte_o == 8'hBC));

  a_r6_viol_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_tick_o && !bypass_i && viol_i && (!load_now_ni || shadow_pend)) |=>
      (sym_kind_o == 2'd2 && sym_byte_o == '0));

  a_r7_raw_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_tick_o && bypass_i && (!load_now_ni || shadow_pend)) |=>
      (raw_o[0] == $past(ctrl_i) && raw_o[RAW_W-1] == $past(viol_i)));

  a_r8_hold_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_tick_o |=> $stable(sym_kind_o) && $stable(sym_byte_o) && $stable(raw_o));

  a_r9_rd_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_strobe_no) |-> $past(byte_tick_o));
endmodule

bind tx_input_stage tx_input_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_i),
  .viol_i      (viol_i),
  .load_now_ni (load_now_ni),
  .load_next_ni(load_next_ni),
  .bypass_i    (bypass_i),
  .byte_tick_o (byte_tick_o),
  .sym_kind_o  (sym_kind_o),
  .sym_byte_o  (sym_byte_o),
  .raw_o       (raw_o),
  .rd_strobe_no(rd_strobe_no)
);

// File: tb/tx_input_stage_tb_top.sv
`timescale 1ns/1ps
module tx_input_stage_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       ctrl_i = 1'b0;
  logic       viol_i = 1'b0;
  logic       load_now_ni = 1'b1;
  logic       load_next_ni = 1'b1;
  logic       bypass_i = 1'b0;
  logic       byte_tick_o;
  logic [1:0] sym_kind_o;
  logic [7:0] sym_byte_o;
  logic [9:0] raw_o;
  logic       rd_strobe_no;

  int total = 0;
  int bad = 0;
  bit pend = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tx_input_stage dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .ctrl_i(ctrl_i),
    .viol_i(viol_i), .load_now_ni(load_now_ni), .load_next_ni(load_next_ni),
    .bypass_i(bypass_i), .byte_tick_o(byte_tick_o), .sym_kind_o(sym_kind_o),
    .sym_byte_o(sym_byte_o), .raw_o(raw_o), .rd_strobe_no(rd_strobe_no)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entry and exit: at a negedge with byte_tick_o high
  task automatic do_byte(input bit now_n, input bit next_n, input bit c,
                         input bit v, input bit byp, input logic [7:0] d);
    bit          ld;
    logic [1:0]  ek;
    logic [7:0]  eb;
    logic [9:0]  er;
    load_now_ni  = now_n;
    load_next_ni = next_n;
    ctrl_i = c; viol_i = v; bypass_i = byp; data_i = d;
    ld = !now_n || pend;
    pend = !next_n;
    if (!ld) begin
      ek = 2'd3; eb = 8'hBC; er = byp ? 10'h17C : 10'h000;
    end else if (byp) begin
      ek = 2'd0; eb = d; er = {v, d, c};
    end else if (v) begin
      ek = 2'd2; eb = 8'h00; er = '0;
    end else begin
      ek = c ? 2'd1 : 2'd0; eb = d; er = '0;
    end
    for (int s = 0; s < 10; s++) begin
      @(negedge clk_i);
      // scramble inputs mid-byte: must have no effect (R1, R8)
      data_i = ~d; ctrl_i = ~c; viol_i = ~v;
      load_now_ni = ~now_n; load_next_ni = ~next_n;
      if (s == 0 || s == 9) begin
        check(ld ? (byp ? "R7" : (v ? "R6" : "R5")) : "R4", {30'd0, sym_kind_o}, {30'd0, ek});
        check(ld ? "R2/R3 byte" : "R4 byte", {24'd0, sym_byte_o}, {24'd0, eb});
        check("R8 raw", {22'd0, raw_o}, {22'd0, er});
      end
      check("R9 rd", {31'd0, rd_strobe_no}, {31'd0, !(!now_n && s < 6)});
      check("R1 tick", {31'd0, byte_tick_o}, {31'd0, s == 9});
    end
    data_i = d; ctrl_i = c; viol_i = v;
    load_now_ni = now_n; load_next_ni = next_n;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 kind", {30'd0, sym_kind_o}, 32'd3);
    check("R10 byte", {24'd0, sym_byte_o}, 32'hBC);
    check("R10 raw", {22'd0, raw_o}, 32'd0);
    check("R10 rd", {31'd0, rd_strobe_no}, 32'd1);
    rst_ni = 1'b1;
    while (!byte_tick_o) @(negedge clk_i);
    // R3: both enables toward the same edge give one load, then fill
    do_byte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
    do_byte(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h22);
    do_byte(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33);
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [7:0] d;
        d = 8'((p * 8'h5B) ^ (k * 8'h13) ^ (8'h01 << p));
        do_byte(k[0], k[1], k[2], k[3], k[4], d);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule